// File: doc/BRIEF.md
# Six-Source Interrupt Priority Vector Unit

This unit is the interrupt front end of a two-channel serial controller. Each channel presents three request strobes (receive, transmit, external/status), six sources in all, which the unit latches as pending bits while the master enable is set. It ranks the pending sources in a fixed order and drives an active-low interrupt line. It also joins a daisy chain of peripherals through an enable-in and enable-out pair, an acknowledge strobe and a return-from-interrupt strobe.

On acknowledge, the highest eligible source moves from pending to in-service. The unit returns a vector that can carry a 3-bit status code naming that source. A software command, or the return strobe, retires the highest in-service source. The vector register and the master control register are single registers shared by both channels. A vector read made on behalf of channel B always shows the status code of the highest pending source. A read made on behalf of channel A shows the stored vector unchanged.

Top module: `sixsrc_irq_unit`

## Requirements
- R1: After reset, no source is pending or in service, `int_n` is 1, `ieo` follows `iei`, and both shared registers read 0 (vector 0x00, so `vec_rd` is 0x00).
- R2: A request strobe on `req_i[k]` sets pending bit k on the next clock edge only when master control bit 3 (master enable) is 1. With that bit 0, requests are dropped and `pend_stat` stays 0.
- R3: Source index 0 has the highest priority and index 5 the lowest: 0 channel A receive, 1 A transmit, 2 A external/status, 3 channel B receive, 4 B transmit, 5 B external/status. `pend_stat[5-k]` shows pending bit k, so D5..D3 are A receive/transmit/external and D2..D0 are the same sources for B.
- R4: `int_n` is 0 exactly when `iei` is 1 and some pending source has no source of equal or higher priority in service.
- R5: An `inta` strobe while `int_n` is 0 moves the highest eligible source from pending to in-service. `ieo` is 0 whenever any source is in service, and otherwise equals `iei`.
- R6: While a source is in service, lower-priority pending sources do not assert `int_n`, and a higher-priority pending source still does (nesting).
- R7: Either the `cmd_reset_ius` strobe or the `reti` strobe clears only the highest-priority in-service bit.
- R8: The status code of source k is the source kind (transmit 0, external/status 1, receive 2) plus 4 for channel A. This gives 6, 4, 5, 2, 0, 1 for indices 0 to 5.
- R9: With master control bit 4 at 0, the code replaces vector bits 3:1. With it at 1, code bits 2, 1, 0 replace vector bits 4, 5, 6 (reversed order). All other vector bits keep the stored value.
- R10: `ack_vec`, updated on the edge that takes an acknowledge, is the modified vector of the granted source if master control bit 0 (vector includes status) is 1, and the stored vector otherwise.
- R11: `vec_rd` with `rd_chan_b`=1 is the vector modified by the highest pending source, whatever the value of bit 0. With `rd_chan_b`=0, or with nothing pending, it is the stored vector.
- R12: `wr_sel`=0 writes the shared vector register and `wr_sel`=1 writes the shared master control register. Both take effect on the clock edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 6 | Request strobes, index 0 highest priority |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 vector register, 1 master control register |
| wr_data | input | 8 | Write data |
| cmd_reset_ius | input | 1 | Retire highest in-service source |
| iei | input | 1 | Daisy-chain enable in |
| inta | input | 1 | Interrupt acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| rd_chan_b | input | 1 | Vector read on behalf of channel B |
| vec_rd | output | 8 | Vector register read value |
| ack_vec | output | 8 | Vector captured at acknowledge |
| pend_stat | output | 6 | Pending bits, A rx on D5 to B ext on D0 |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Daisy-chain enable out |

## Verification
The assertions check on every cycle that requests never become pending while the master enable is off, and that `int_n` stays high without `iei`. They also check that `ieo` falls whenever anything is in service, that an acknowledge adds exactly one in-service bit, and that a retire command removes exactly one. Only the directed scenarios can show that the ranking picks the right source, that nesting and blocking follow the in-service state, and that the status codes land in the right vector bits in both placements. The same holds for the channel B read being modified regardless of the include-status bit.

// File: rtl/sixsrc_irq_pkg.sv
// Shared constants and the source-to-status-code mapping of the interrupt unit.
// Assumes six sources ordered A rx, A tx, A ext, B rx, B tx, B ext.
package sixsrc_irq_pkg;
    localparam int NSRC    = 6;
    localparam int VW      = 8;
    localparam int CODE_W  = 3;
    localparam int PER_CH  = 3;
    localparam int CTL_VIS  = 0;
    localparam int CTL_MIE  = 3;
    localparam int CTL_SHSL = 4;

    // Status code of a source index: kind code plus channel A offset.
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        logic [CODE_W-1:0] c;
        case (idx % PER_CH)
            0:       c = 3'd2;
            1:       c = 3'd0;
            default: c = 3'd1;
        endcase
        if (idx < PER_CH) c = c | 3'd4;
        return c;
    endfunction
endpackage

// File: rtl/irq_prio_pick.sv
// Picks the lowest-index set bit of a request vector (index 0 wins).
// Assumes nothing about the input; output is one-hot or zero.
module irq_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pick
            // a bit wins when no lower index was set
            assign pick[g]   = req[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req[g];
        end
    endgenerate
    assign any = seen[N];
endmodule

// File: rtl/irq_state.sv
// Pending and in-service state of the six sources, with daisy-chain grant.
// Assumes request, acknowledge and retire inputs are single-cycle strobes.
module irq_state #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         mie,
    input  logic         iei,
    input  logic         inta,
    input  logic         clr_ius,
    output logic [N-1:0] pend,
    output logic [N-1:0] ius,
    output logic [N-1:0] grant,
    output logic         elig_any
);
    logic [N-1:0] elig;
    logic [N-1:0] pick_e;
    logic [N-1:0] pick_s;
    logic         any_s;
    logic [N:0]   blk;
    logic         take;

    assign blk[0] = 1'b0;
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_elig
            // eligible when nothing of equal or higher rank is in service
            assign blk[g+1] = blk[g] | ius[g];
            assign elig[g]  = pend[g] & ~blk[g+1];
        end
    endgenerate

    irq_prio_pick #(.N(N)) i_pick_elig (.req(elig), .pick(pick_e), .any(elig_any));
    irq_prio_pick #(.N(N)) i_pick_svc  (.req(ius),  .pick(pick_s), .any(any_s));

    assign take  = inta & iei & elig_any;
    assign grant = take ? pick_e : '0;

    // latch requests under master enable, clear the granted one
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~grant) | (mie ? req : '0);
    end

    // in-service bits: set on grant, retire the highest on command
    always_ff @(posedge clk) begin
        if (!rst_n) ius <= '0;
        else        ius <= (ius & ~((clr_ius && any_s) ? pick_s : '0)) | grant;
    end

    assert_mie_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mie && !take |=> ($past(pend) == pend));
    assert_ack_adds_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take && !clr_ius |=> $countones(ius) == $countones($past(ius)) + 1);
    assert_retire_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ius && any_s && !take |=> $countones(ius) == $countones($past(ius)) - 1);
endmodule

// File: rtl/irq_vec_build.sv
// Inserts the status code of a one-hot selected source into a base vector.
// Assumes sel is one-hot or zero; zero or mod_en low leaves the base as is.
module irq_vec_build
    import sixsrc_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [VW-1:0] base,
    input  logic [N-1:0]  sel,
    input  logic          mod_en,
    input  logic          shsl,
    output logic [VW-1:0] vec
);
    logic [CODE_W-1:0] code;

    // encode the selected source into its status code
    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++)
            if (sel[i]) code = code | src_code(i);
    end

    // place the code low, or reversed into the upper field
    always_comb begin
        vec = base;
        if (mod_en && (|sel)) begin
            if (shsl) begin
                vec[4] = code[2];
                vec[5] = code[1];
                vec[6] = code[0];
            end else begin
                vec[3:1] = code;
            end
        end
    end
endmodule

// File: rtl/sixsrc_irq_unit.sv
// Top of the six-source interrupt unit: shared registers, state, vectors.
// Assumes one register write port shared by both channels.
module sixsrc_irq_unit
    import sixsrc_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [VW-1:0]   wr_data,
    input  logic            cmd_reset_ius,
    input  logic            iei,
    input  logic            inta,
    input  logic            reti,
    input  logic            rd_chan_b,
    output logic [VW-1:0]   vec_rd,
    output logic [VW-1:0]   ack_vec,
    output logic [NSRC-1:0] pend_stat,
    output logic            int_n,
    output logic            ieo
);
    logic [VW-1:0]   vec_base;
    logic [VW-1:0]   ctl;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] ius;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] top_pend;
    logic            pend_any;
    logic            elig_any;
    logic [VW-1:0]   vec_ack_c;
    logic [VW-1:0]   vec_rdb_c;

    // shared vector and master control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base <= '0;
            ctl      <= '0;
        end else if (wr_en) begin
            if (wr_sel) ctl      <= wr_data;
            else        vec_base <= wr_data;
        end
    end

    irq_state #(.N(NSRC)) i_state (
        .clk(clk), .rst_n(rst_n), .req(req_i), .mie(ctl[CTL_MIE]),
        .iei(iei), .inta(inta), .clr_ius(cmd_reset_ius | reti),
        .pend(pend), .ius(ius), .grant(grant), .elig_any(elig_any)
    );

    irq_prio_pick #(.N(NSRC)) i_pick_pend (.req(pend), .pick(top_pend), .any(pend_any));

    irq_vec_build #(.N(NSRC)) i_vec_ack (
        .base(vec_base), .sel(grant), .mod_en(ctl[CTL_VIS]),
        .shsl(ctl[CTL_SHSL]), .vec(vec_ack_c)
    );
    irq_vec_build #(.N(NSRC)) i_vec_rdb (
        .base(vec_base), .sel(top_pend), .mod_en(1'b1),
        .shsl(ctl[CTL_SHSL]), .vec(vec_rdb_c)
    );

    // capture the vector presented on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_vec <= '0;
        else if (|grant)  ack_vec <= vec_ack_c;
    end

    assign vec_rd = rd_chan_b ? vec_rdb_c : vec_base;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_stat
            assign pend_stat[NSRC-1-g] = pend[g];
        end
    endgenerate

    assign int_n = ~(iei & elig_any);
    assign ieo   = iei & ~(|ius);

    assert_no_int_without_iei_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> int_n);
    assert_ieo_low_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ius) |-> !ieo);
    assert_plain_ack_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) && !ctl[CTL_VIS] |=> ack_vec == $past(vec_base));
    assert_read_a_plain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_chan_b || !pend_any |-> vec_rd == vec_base);
endmodule

// File: tb/test_sixsrc_irq_unit.sv
module test_sixsrc_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] req_i;
    logic       wr_en, wr_sel;
    logic [7:0] wr_data;
    logic       cmd_reset_ius, iei, inta, reti, rd_chan_b;
    logic [7:0] vec_rd, ack_vec;
    logic [5:0] pend_stat;
    logic       int_n, ieo;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sixsrc_irq_unit i_sixsrc_irq_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cmd_reset_ius(cmd_reset_ius), .iei(iei), .inta(inta),
        .reti(reti), .rd_chan_b(rd_chan_b), .vec_rd(vec_rd), .ack_vec(ack_vec),
        .pend_stat(pend_stat), .int_n(int_n), .ieo(ieo)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected vector from R8/R9
    function automatic logic [7:0] exp_vec(input logic [7:0] b, input int k, input logic hi);
        logic [2:0] c;
        logic [7:0] v;
        case (k)
            0: c = 3'd6; 1: c = 3'd4; 2: c = 3'd5;
            3: c = 3'd2; 4: c = 3'd0; default: c = 3'd1;
        endcase
        v = b;
        if (hi) begin v[4] = c[2]; v[5] = c[1]; v[6] = c[0]; end
        else v[3:1] = c;
        return v;
    endfunction

    task automatic cyc(); @(negedge clk); endtask

    task automatic do_reset();
        rst_n = 1'b0; req_i = '0; wr_en = 0; wr_sel = 0; wr_data = '0;
        cmd_reset_ius = 0; iei = 1; inta = 0; reti = 0; rd_chan_b = 0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic wreg(input logic sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d; cyc(); wr_en = 0;
    endtask

    task automatic pulse_req(input logic [5:0] r);
        req_i = r; cyc(); req_i = '0;
    endtask

    task automatic ack(); inta = 1; cyc(); inta = 0; endtask

    task automatic t_reset();
        do_reset();
        chk("R1 int_n", {7'd0, int_n}, 8'd1);
        chk("R1 ieo", {7'd0, ieo}, 8'd1);
        chk("R1 pend", {2'd0, pend_stat}, 8'd0);
        rd_chan_b = 1;
        chk("R1 vec_rd", vec_rd, 8'h00);
        rd_chan_b = 0;
    endtask

    task automatic t_mie_and_map();
        do_reset();
        pulse_req(6'h3F);
        chk("R2 dropped", {2'd0, pend_stat}, 8'd0);
        chk("R2 int_n", {7'd0, int_n}, 8'd1);
        wreg(1, 8'h08);  // R12 control write
        pulse_req(6'b010000);            // B transmit, index 4
        chk("R3 map idx4", {2'd0, pend_stat}, 8'b000010);
        pulse_req(6'b000001);            // A receive, index 0
        chk("R3 map idx0", {2'd0, pend_stat}, 8'b100010);
        iei = 0; #1;
        chk("R4 iei low", {7'd0, int_n}, 8'd1);
        iei = 1; #1;
        chk("R4 asserted", {7'd0, int_n}, 8'd0);
    endtask

    task automatic t_nest();
        do_reset();
        wreg(1, 8'h08);
        pulse_req(6'b010100);            // idx 2 and idx 4
        ack();
        chk("R5 granted idx2", {2'd0, pend_stat}, 8'b000010);
        chk("R5 ieo low", {7'd0, ieo}, 8'd0);
        chk("R6 lower blocked", {7'd0, int_n}, 8'd1);
        pulse_req(6'b000001);
        chk("R6 higher nests", {7'd0, int_n}, 8'd0);
        ack();
        chk("R6 idx0 taken", {2'd0, pend_stat}, 8'b000010);
        cmd_reset_ius = 1; cyc(); cmd_reset_ius = 0;
        chk("R7 idx2 still served", {7'd0, int_n}, 8'd1);
        chk("R7 ieo still low", {7'd0, ieo}, 8'd0);
        reti = 1; cyc(); reti = 0;
        chk("R7 ieo released", {7'd0, ieo}, 8'd1);
        chk("R7 idx4 unblocked", {7'd0, int_n}, 8'd0);
    endtask

    task automatic t_vectors();
        do_reset();
        wreg(0, 8'hFF);
        wreg(1, 8'h08);                  // include-status off
        pulse_req(6'b000010);            // idx 1
        ack();
        chk("R10 plain ack", ack_vec, 8'hFF);
        wreg(1, 8'h09);                  // include-status on, low field
        pulse_req(6'b000010);
        reti = 1; cyc(); reti = 0;
        ack();
        chk("R10 R9 low field", ack_vec, exp_vec(8'hFF, 1, 0));
        wreg(1, 8'h19);
        pulse_req(6'b000010);
        reti = 1; cyc(); reti = 0;
        ack();
        chk("R9 high field", ack_vec, exp_vec(8'hFF, 1, 1));
        reti = 1; cyc(); reti = 0;
        wreg(0, 8'h00);
        wreg(1, 8'h08);                  // include-status off
        pulse_req(6'b100001);            // idx 0 and idx 5
        rd_chan_b = 1; #1;
        chk("R11 B read modified", vec_rd, exp_vec(8'h00, 0, 0));
        chk("R8 code A rx", vec_rd, 8'h0C);
        rd_chan_b = 0; #1;
        chk("R11 A read plain", vec_rd, 8'h00);
        wreg(1, 8'h18);
        rd_chan_b = 1; #1;
        chk("R9 B read high", vec_rd, 8'h30);
        ack();                           // idx 0 served, idx 5 highest pending
        chk("R8 code B ext", vec_rd, exp_vec(8'h00, 5, 1));
        rd_chan_b = 0;
    endtask

    initial begin
        t_reset();
        t_mie_and_map();
        t_nest();
        t_vectors();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule